// File: doc/BRIEF.md
# Split-Bank 16-Bit Memory Interface

This block sits between a 16-bit processor bus, which puts out a 20-bit byte address time-multiplexed with its data, and memory built from two 8-bit banks. One bank stores every even-addressed byte and the other stores every odd-addressed byte. On the address phase the processor pulses an address-latch strobe. The block captures the address, including bit zero, and the active-low high-byte enable on that strobe. It then holds them for the rest of the bus cycle while the shared lines carry data.

From the two captured selection bits the block decides which bank takes part in the cycle. It gates the write command into a separate write strobe for each bank. It routes the even bank to data bits 7:0 and the odd bank to data bits 15:8. A byte at either address, or an aligned 16-bit word, completes in one bus cycle. The banks are small parameterised arrays indexed by the low latched row bits, so the whole path can be exercised in simulation.

Top module: `splitbank_mem_if`

## Requirements
- R1: After reset both bank enables and both write strobes are low, and read data is zero even with the read command high.
- R2: Address, bit zero and the high-byte enable are captured at a rising clock edge where the latch strobe is high. They are held unchanged while the strobe is low, whatever the bus lines do.
- R3: The even-bank enable `lo_en` is high exactly when the captured address bit 0 is 0.
- R4: The odd-bank enable `hi_en` is high exactly when the captured high-byte enable `bhe_n` is 0 (active low).
- R5: Captured bit 0 = 1 with `bhe_n` = 1 is a no-operation: neither bank is enabled, nothing is written, and reads return zero.
- R6: Each bank's write strobe is high exactly when the write command is high and that bank is enabled. A write changes only the enabled bank(s).
- R7: The even bank exchanges data on bits 7:0 and the odd bank on bits 15:8. Both use the row given by captured address bits [BANK_AW:1], and higher address bits are not decoded in the model.
- R8: While the read command is high, each enabled lane carries its bank's byte and each disabled lane reads zero. While it is low, read data is all zero.
- R9: An aligned word access (bit 0 = 0, `bhe_n` = 0) enables both banks and moves 16 bits in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ale | input | 1 | Address-latch strobe, captures address and high-byte enable |
| ad_addr | input | ADDR_W | Byte address on the multiplexed bus |
| bhe_n | input | 1 | Active-low high-byte enable, driven with the address |
| rd | input | 1 | Read command |
| wr | input | 1 | Write command |
| wdata | input | 16 | Write data, two byte lanes |
| rdata | output | 16 | Read data, two byte lanes |
| lo_en | output | 1 | Even-bank enable |
| hi_en | output | 1 | Odd-bank enable |
| lo_we | output | 1 | Even-bank write strobe |
| hi_we | output | 1 | Odd-bank write strobe |

## Verification
The bench sweeps every byte address of a 32-row configuration with all four selection combinations for both writes and reads. It compares each result against a byte-array model. A design that decoded bit 0 with the wrong polarity, or treated the high-byte enable as active high, would write the wrong bank and corrupt the neighbouring byte of the word. The no-operation combination is read back afterwards to show that a design leaking a write into either bank changed stored data. After the strobe falls, the bus lines are inverted, so a transparent latch or a decode taken from the live lines gives the wrong lane. Reads with `rd` low and reads of disabled lanes must return zero, which catches a data path that is never gated.

// File: rtl/splitbank_pkg.sv
package splitbank_pkg;
   localparam int unsigned LANES  = 2;
   localparam int unsigned LANE_W = 8;
   localparam int unsigned BUS_W  = LANES * LANE_W;

   typedef struct packed {
      logic hi;
      logic lo;
   } lane_sel_t;
endpackage

// File: rtl/splitbank_addr_latch.sv
module splitbank_addr_latch #(
   parameter int unsigned ADDR_W = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ale,
   input  logic [ADDR_W-1:0] ad_addr,
   input  logic              bhe_n,
   output logic [ADDR_W-2:0] row_q,
   output logic              a0_q,
   output logic              bhe_n_q
);
   // Idle value a0=1, bhe_n=1 selects no bank.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_q   <= '0;
         a0_q    <= 1'b1;
         bhe_n_q <= 1'b1;
      end else if (ale) begin
         row_q   <= ad_addr[ADDR_W-1:1];
         a0_q    <= ad_addr[0];
         bhe_n_q <= bhe_n;
      end
   end
endmodule

// File: rtl/splitbank_lane_decode.sv
module splitbank_lane_decode
   import splitbank_pkg::*;
(
   input  logic      a0_q,
   input  logic      bhe_n_q,
   input  logic      wr,
   output lane_sel_t en,
   output lane_sel_t we
);
   always_comb begin
      en.lo = ~a0_q;
      en.hi = ~bhe_n_q;
      we.lo = wr & en.lo;
      we.hi = wr & en.hi;
   end
endmodule

// File: rtl/splitbank_byte_bank.sv
module splitbank_byte_bank #(
   parameter int unsigned AW = 5,
   parameter int unsigned DW = 8
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] idx,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);
   localparam int unsigned DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[idx] <= wdata;
   end

   assign rdata = mem[idx];
endmodule

// File: rtl/splitbank_mem_if.sv
module splitbank_mem_if
   import splitbank_pkg::*;
#(
   parameter int unsigned ADDR_W  = 20,
   parameter int unsigned BANK_AW = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ale,
   input  logic [ADDR_W-1:0] ad_addr,
   input  logic              bhe_n,
   input  logic              rd,
   input  logic              wr,
   input  logic [BUS_W-1:0]  wdata,
   output logic [BUS_W-1:0]  rdata,
   output logic              lo_en,
   output logic              hi_en,
   output logic              lo_we,
   output logic              hi_we
);
   localparam int unsigned ROW_W = ADDR_W - 1;

   if (ADDR_W < 2) begin : g_bad_addr
      $error("splitbank_mem_if: ADDR_W must be at least 2");
   end
   if (BANK_AW < 1 || BANK_AW > ROW_W || BANK_AW > 12) begin : g_bad_bank
      $error("splitbank_mem_if: BANK_AW must lie in 1..min(ADDR_W-1,12)");
   end

   logic [ROW_W-1:0] row_q;
   logic             a0_q;
   logic             bhe_n_q;
   lane_sel_t        en;
   lane_sel_t        we;
   logic [LANES-1:0] en_v;
   logic [LANES-1:0] we_v;

   splitbank_addr_latch #(.ADDR_W(ADDR_W)) u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .ale     (ale),
      .ad_addr (ad_addr),
      .bhe_n   (bhe_n),
      .row_q   (row_q),
      .a0_q    (a0_q),
      .bhe_n_q (bhe_n_q)
   );

   splitbank_lane_decode u_dec (
      .a0_q    (a0_q),
      .bhe_n_q (bhe_n_q),
      .wr      (wr),
      .en      (en),
      .we      (we)
   );

   assign en_v  = {en.hi, en.lo};
   assign we_v  = {we.hi, we.lo};
   assign lo_en = en.lo;
   assign hi_en = en.hi;
   assign lo_we = we.lo;
   assign hi_we = we.hi;

   // Lane 0 is the even bank on bits 7:0, lane 1 the odd bank on 15:8.
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [LANE_W-1:0] bank_q;

      splitbank_byte_bank #(.AW(BANK_AW), .DW(LANE_W)) u_bank (
         .clk   (clk),
         .we    (we_v[l]),
         .idx   (row_q[BANK_AW-1:0]),
         .wdata (wdata[l*LANE_W +: LANE_W]),
         .rdata (bank_q)
      );

      assign rdata[l*LANE_W +: LANE_W] = (rd && en_v[l]) ? bank_q : '0;
   end
endmodule

// File: rtl/splitbank_mem_if_chk.sv
module splitbank_mem_if_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        ale,
   input logic        addr0,
   input logic        bhe_n,
   input logic        rd,
   input logic        wr,
   input logic [15:0] rdata,
   input logic        lo_en,
   input logic        hi_en,
   input logic        lo_we,
   input logic        hi_we
);
   p_reset_idle_r1: assert property (@(posedge clk)
      !rst_n |=> (!lo_en && !hi_en));

   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !ale |=> $stable({lo_en, hi_en}));

   p_even_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ale |=> (lo_en == !$past(addr0)));

   p_odd_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ale |=> (hi_en == !$past(bhe_n)));

   p_noop_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!lo_en && !hi_en) |-> (rdata == 16'h0 && !lo_we && !hi_we));

   p_lo_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
      lo_we |-> (wr && lo_en));

   p_hi_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
      hi_we |-> (wr && hi_en));

   p_idle_lanes_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd || (!lo_en && rdata[7:0] == 8'h0) || lo_en) && (!rd ? rdata == 16'h0 : 1'b1));

   p_hi_lane_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && !hi_en) |-> (rdata[15:8] == 8'h0));
endmodule

bind splitbank_mem_if splitbank_mem_if_chk u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .ale   (ale),
   .addr0 (ad_addr[0]),
   .bhe_n (bhe_n),
   .rd    (rd),
   .wr    (wr),
   .rdata (rdata),
   .lo_en (lo_en),
   .hi_en (hi_en),
   .lo_we (lo_we),
   .hi_we (hi_we)
);

// File: tb/splitbank_mem_if_test.sv
module splitbank_mem_if_test;
   localparam int ADDR_W  = 20;
   localparam int BANK_AW = 5;
   localparam int NBYTES  = 2 << BANK_AW;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              ale = 1'b0;
   logic [ADDR_W-1:0] ad_addr = '0;
   logic              bhe_n = 1'b1;
   logic              rd = 1'b0;
   logic              wr = 1'b0;
   logic [15:0]       wdata = '0;
   logic [15:0]       rdata;
   logic              lo_en, hi_en, lo_we, hi_we;

   int checks = 0;
   int errors = 0;
   logic [7:0] model [NBYTES];

   always #5 clk = ~clk;

   splitbank_mem_if #(.ADDR_W(ADDR_W), .BANK_AW(BANK_AW)) uut (
      .clk(clk), .rst_n(rst_n), .ale(ale), .ad_addr(ad_addr), .bhe_n(bhe_n),
      .rd(rd), .wr(wr), .wdata(wdata), .rdata(rdata),
      .lo_en(lo_en), .hi_en(hi_en), .lo_we(lo_we), .hi_we(hi_we)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [ADDR_W-1:0] full_addr(input int a);
      return ADDR_W'((((a * 13) & 16'h3FFF) << 6) | (a & 6'h3F));
   endfunction

   task automatic latch_cycle(input logic [ADDR_W-1:0] a, input logic b);
      @(negedge clk);
      ale = 1'b1; ad_addr = a; bhe_n = b;
      @(negedge clk);
      ale = 1'b0; ad_addr = ~a; bhe_n = ~b;
   endtask

   task automatic write_op(input int a, input logic b, input logic [15:0] d);
      logic lo, hi;
      int   ev;
      lo = (a % 2) == 0;
      hi = !b;
      ev = (a & (NBYTES - 1)) & ~1;
      latch_cycle(full_addr(a), b);
      wr = 1'b1; wdata = d;
      #1;
      check(lo ? "R3 even enable" : "R3 even disable", 32'(lo_en), 32'(lo));
      check(hi ? "R4 odd enable" : "R4 odd disable", 32'(hi_en), 32'(hi));
      check((!lo && !hi) ? "R5 noop strobes" : "R6 lo strobe", 32'(lo_we), 32'(lo));
      check((!lo && !hi) ? "R5 noop strobes" : "R6 hi strobe", 32'(hi_we), 32'(hi));
      if (lo) model[ev]     = d[7:0];
      if (hi) model[ev + 1] = d[15:8];
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic read_op(input int a, input logic b);
      logic        lo, hi;
      int          ev;
      logic [15:0] exp;
      string       tag;
      lo  = (a % 2) == 0;
      hi  = !b;
      ev  = (a & (NBYTES - 1)) & ~1;
      exp = {hi ? model[ev + 1] : 8'h00, lo ? model[ev] : 8'h00};
      if (lo && hi)       tag = "R9 word read";
      else if (!lo && !hi) tag = "R5 noop read";
      else                tag = "R7 byte lane read";
      latch_cycle(full_addr(a), b);
      #1;
      check("R8 rd low zero", 32'(rdata), 32'h0);
      @(negedge clk);
      rd = 1'b1;
      #1;
      check(tag, 32'(rdata), 32'(exp));
      rd = 1'b0;
   endtask

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rd = 1'b1;
      #1;
      check("R1 reset lo_en", 32'(lo_en), 32'h0);
      check("R1 reset hi_en", 32'(hi_en), 32'h0);
      check("R1 reset rdata", 32'(rdata), 32'h0);
      rd = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      wr = 1'b1;
      #1;
      check("R1 reset lo_we", 32'(lo_we), 32'h0);
      check("R1 reset hi_we", 32'(hi_we), 32'h0);
      wr = 1'b0;

      // Fill every row with aligned words (R9), then overwrite bytes (R6, R7).
      for (int r = 0; r < NBYTES; r += 2)
         write_op(r, 1'b0, 16'((r * 91 + 17) ^ ((r * 7) << 8)));
      for (int a = 0; a < NBYTES; a++)
         for (int b = 0; b < 2; b++)
            read_op(a, b[0]);

      for (int a = 0; a < NBYTES; a++) begin
         write_op(a, a[0] ? 1'b0 : 1'b1, 16'(((a * 37 + 5) << 8) | ((a * 53 + 11) & 8'hFF)));
         // Read the whole word back: the other byte must be untouched.
         read_op(a & ~1, 1'b0);
      end

      // No-operation writes must leave both banks alone (R5).
      for (int a = 1; a < NBYTES; a += 2) begin
         write_op(a, 1'b1, 16'hDEAD);
         read_op(a & ~1, 1'b0);
         read_op(a, 1'b1);
      end

      // Hold: bus lines flip while strobe stays low (R2).
      latch_cycle(full_addr(6), 1'b1);
      repeat (4) begin
         @(negedge clk);
         ad_addr = ad_addr ^ 20'h5_5555; bhe_n = ~bhe_n;
         #1;
         check("R2 hold lo_en", 32'(lo_en), 32'h1);
         check("R2 hold hi_en", 32'(hi_en), 32'h0);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule